// File: doc/BRIEF.md
# Bandwidth-Limited In-Order Retire Unit

This block sits at the head of a reorder buffer and decides, every cycle, how many of the oldest entries of the granted thread leave the buffer. The buffer presents a window of its `WIN` oldest entries with their attributes. The unit scans them in age order and retires up to `COMMIT_W` completed instructions. It writes their architectural-to-physical register mappings into the commit map and reports the youngest retired sequence number. Entries already cancelled by an earlier squash are dropped without using commit bandwidth.

The scan stops early at entries that cannot retire normally. A non-speculative, store-conditional or barrier entry that has not executed is sent back to execution with a sequence-number request. This only happens when no store is waiting to write back and nothing has retired earlier in the same cycle. A load that has not executed is handed back as an uncached access. A faulting entry starts the trap path under the same drain and first-slot rule. The thread then waits a fixed latency before the trap squash pulse, and nothing retires in the meantime. The unit also tracks buffer occupancy, keeps the architectural PC pair, and counts the cycles in which the full commit bandwidth was used.

The head window is a valid-only stream toward this block, and `pop_cnt` acts as its ready. Entry `i` of the window is consumed in a cycle exactly when `i < pop_cnt`. The buffer must shift its head by `pop_cnt` at the clock edge. A valid entry that is not consumed must be presented again, unchanged, in the next cycle. Nothing else applies back-pressure. When `clr_ready` is high, the entry at window index `pop_cnt` must have its ready bit cleared by the buffer.

Top module: `retire_unit`

## Requirements
- R1: The number of non-squashed entries retired in one cycle, reported on `commit_cnt`, never exceeds `COMMIT_W`. Once that many have retired, the scan stops.
- R2: The scan walks the window from index 0 upward. It stops at the first entry that is not valid or not ready. It retires nothing when `grant` is low.
- R3: A squashed, ready entry is removed (counted in `pop_cnt`) without being counted in `commit_cnt`, as long as fewer than `COMMIT_W` entries have retired so far.
- R4: An unexecuted entry with `hd_nonspec` or `hd_barrier` set stops the scan. It raises `nonspec_vld`, drives its sequence number on `req_seq` and raises `clr_ready`, but only when `stores_pend` is low and `commit_cnt` is 0 at that point. Otherwise it only stops the scan.
- R5: An unexecuted entry without those flags but with `hd_load` set raises `uncached_vld`, drives `req_seq` and `clr_ready`, and stops the scan. Any other unexecuted entry just stops it.
- R6: An executed entry with `hd_fault` set is never removed. It raises `trap_start` only when `stores_pend` is low and nothing has retired before it that cycle. After `trap_start`, the unit is busy for `TRAP_LAT` cycles and retires nothing. `trap_squash` pulses in the last of those cycles.
- R7: Each executed, fault-free entry retires. If `hd_dst_en` is set, commit-map port k (k = number of earlier retirements this cycle) is written with its `hd_arch`/`hd_phys`. `done_vld`/`done_seq` give the youngest retired sequence number.
- R8: After a cycle that retired at least one entry, `arch_pc` equals that cycle's last retired `hd_npc`, and `arch_npc` equals it plus `INST_BYTES`. Otherwise both hold. Both reset to 0.
- R9: Occupancy changes by `alloc_cnt - pop_cnt` per cycle. After each edge, `rob_free` = `ROB_SZ` minus occupancy and `rob_empty` shows occupancy 0. `occ_upd` pulses one cycle after any cycle with nonzero `alloc_cnt` or `pop_cnt`.
- R10: `bw_events` increments by one after every cycle in which `commit_cnt` equals `COMMIT_W`. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Thread selected for retirement this cycle |
| stores_pend | input | 1 | Stores still waiting to write back |
| alloc_cnt | input | ALLOC_W | Entries inserted into the buffer this cycle |
| hd_valid | input | WIN | Window entry present |
| hd_ready | input | WIN | Entry may be considered for retirement |
| hd_squashed | input | WIN | Entry cancelled by an earlier squash |
| hd_executed | input | WIN | Entry has executed |
| hd_nonspec | input | WIN | Non-speculative or store-conditional class |
| hd_barrier | input | WIN | Memory or write barrier class |
| hd_load | input | WIN | Load class |
| hd_fault | input | WIN | Entry raised a fault |
| hd_dst_en | input | WIN | Entry writes a destination register |
| hd_seq | input | WIN*SEQ_W | Sequence numbers |
| hd_arch | input | WIN*AR_W | Architectural destination indices |
| hd_phys | input | WIN*PR_W | Physical destination indices |
| hd_npc | input | WIN*PC_W | Next-PC of each entry |
| pop_cnt | output | POP_W | Entries removed from the head this cycle |
| commit_cnt | output | CC_W | Non-squashed entries retired this cycle |
| map_we | output | COMMIT_W | Commit-map write enables per port |
| map_arch | output | COMMIT_W*AR_W | Commit-map write index per port |
| map_phys | output | COMMIT_W*PR_W | Commit-map write data per port |
| nonspec_vld | output | 1 | Non-speculative execute request |
| uncached_vld | output | 1 | Uncached load request |
| req_seq | output | SEQ_W | Sequence number for either request |
| clr_ready | output | 1 | Clear ready bit of the entry at index `pop_cnt` |
| trap_start | output | 1 | Fault accepted, trap path starts |
| trap_busy | output | 1 | Trap pending, retirement halted |
| trap_squash | output | 1 | Delayed trap squash pulse |
| done_vld | output | 1 | At least one entry retired |
| done_seq | output | SEQ_W | Youngest retired sequence number |
| arch_pc | output | PC_W | Architectural PC |
| arch_npc | output | PC_W | Architectural next PC |
| rob_free | output | OCC_W | Free buffer entries |
| rob_empty | output | 1 | Buffer empty |
| occ_upd | output | 1 | Occupancy changed in the previous cycle |
| bw_events | output | BW_W | Cycles that used the full commit bandwidth |

## Verification
The bench drives windows that mix squashed entries between completed ones. This catches a unit that charges dropped entries against the bandwidth, which would retire too few, or one that keeps dropping them after the width is reached, which would pop too many. Non-speculative and faulting entries are placed both in the first slot and behind a retirement, and are combined with pending stores. A unit that ignores the first-slot or drain rule would issue requests or traps too early. The trap latency window is checked cycle by cycle, so a halt that ends one cycle early or late shows up as extra or missing pops. Commit-map port indexing is checked against squashed gaps, where a unit indexing by window position would write the wrong port.

// File: rtl/retire_pkg.sv
`timescale 1ns/1ps
package retire_pkg;

  typedef enum logic [2:0] {
    HA_HALT,      // cannot proceed, scan ends
    HA_DROP,      // squashed: remove without bandwidth
    HA_NONSPEC,   // unexecuted serialising entry
    HA_UNCACHED,  // unexecuted load
    HA_FAULT,     // faulting entry
    HA_RETIRE     // normal retirement
  } head_act_e;

  function automatic head_act_e classify(
    input logic vld, input logic rdy, input logic sq, input logic ex,
    input logic ns, input logic bar, input logic ld, input logic flt);
    if (!vld || !rdy)   return HA_HALT;
    if (sq)             return HA_DROP;
    if (!ex) begin
      if (ns || bar)    return HA_NONSPEC;
      if (ld)           return HA_UNCACHED;
      return HA_HALT;
    end
    if (flt)            return HA_FAULT;
    return HA_RETIRE;
  endfunction

endpackage

// File: rtl/retire_scan.sv
`timescale 1ns/1ps
module retire_scan
  import retire_pkg::*;
#(
  parameter int COMMIT_W = 2,
  parameter int WIN      = 4,
  parameter int SEQ_W    = 8,
  parameter int AR_W     = 5,
  parameter int PR_W     = 6,
  parameter int PC_W     = 16,
  localparam int POP_W   = $clog2(WIN + 1),
  localparam int CC_W    = $clog2(COMMIT_W + 1)
) (
  input  logic                     en,
  input  logic                     stores_pend,
  input  logic [WIN-1:0]           hd_valid,
  input  logic [WIN-1:0]           hd_ready,
  input  logic [WIN-1:0]           hd_squashed,
  input  logic [WIN-1:0]           hd_executed,
  input  logic [WIN-1:0]           hd_nonspec,
  input  logic [WIN-1:0]           hd_barrier,
  input  logic [WIN-1:0]           hd_load,
  input  logic [WIN-1:0]           hd_fault,
  input  logic [WIN-1:0]           hd_dst_en,
  input  logic [WIN*SEQ_W-1:0]     hd_seq,
  input  logic [WIN*AR_W-1:0]      hd_arch,
  input  logic [WIN*PR_W-1:0]      hd_phys,
  input  logic [WIN*PC_W-1:0]      hd_npc,
  output logic [POP_W-1:0]         pop_cnt,
  output logic [CC_W-1:0]          commit_cnt,
  output logic [COMMIT_W-1:0]      map_we,
  output logic [COMMIT_W*AR_W-1:0] map_arch,
  output logic [COMMIT_W*PR_W-1:0] map_phys,
  output logic                     nonspec_vld,
  output logic                     uncached_vld,
  output logic [SEQ_W-1:0]         req_seq,
  output logic                     clr_ready,
  output logic                     trap_go,
  output logic                     done_vld,
  output logic [SEQ_W-1:0]         done_seq,
  output logic [PC_W-1:0]          last_npc
);

  head_act_e act [WIN];

  for (genvar g = 0; g < WIN; g++) begin : g_cls
    assign act[g] = classify(hd_valid[g], hd_ready[g], hd_squashed[g],
                             hd_executed[g], hd_nonspec[g], hd_barrier[g],
                             hd_load[g], hd_fault[g]);
  end

  always_comb begin
    logic halted;
    int   npop;
    int   ncom;
    halted       = !en;
    npop         = 0;
    ncom         = 0;
    map_we       = '0;
    map_arch     = '0;
    map_phys     = '0;
    nonspec_vld  = 1'b0;
    uncached_vld = 1'b0;
    req_seq      = '0;
    clr_ready    = 1'b0;
    trap_go      = 1'b0;
    done_vld     = 1'b0;
    done_seq     = '0;
    last_npc     = '0;
    for (int i = 0; i < WIN; i++) begin
      if (!halted) begin
        if (ncom == COMMIT_W) begin
          halted = 1'b1;
        end else begin
          unique case (act[i])
            HA_DROP: npop = npop + 1;
            HA_NONSPEC: begin
              if (!stores_pend && ncom == 0) begin
                nonspec_vld = 1'b1;
                req_seq     = hd_seq[i*SEQ_W +: SEQ_W];
                clr_ready   = 1'b1;
              end
              halted = 1'b1;
            end
            HA_UNCACHED: begin
              uncached_vld = 1'b1;
              req_seq      = hd_seq[i*SEQ_W +: SEQ_W];
              clr_ready    = 1'b1;
              halted       = 1'b1;
            end
            HA_FAULT: begin
              if (!stores_pend && ncom == 0) trap_go = 1'b1;
              halted = 1'b1;
            end
            HA_RETIRE: begin
              if (hd_dst_en[i]) begin
                map_we[ncom]                 = 1'b1;
                map_arch[ncom*AR_W +: AR_W]  = hd_arch[i*AR_W +: AR_W];
                map_phys[ncom*PR_W +: PR_W]  = hd_phys[i*PR_W +: PR_W];
              end
              done_vld = 1'b1;
              done_seq = hd_seq[i*SEQ_W +: SEQ_W];
              last_npc = hd_npc[i*PC_W +: PC_W];
              ncom     = ncom + 1;
              npop     = npop + 1;
            end
            default: halted = 1'b1;
          endcase
        end
      end
    end
    pop_cnt    = POP_W'(npop);
    commit_cnt = CC_W'(ncom);
  end

endmodule

// File: rtl/retire_occ.sv
`timescale 1ns/1ps
module retire_occ #(
  parameter int ROB_SZ  = 16,
  parameter int POP_W   = 3,
  parameter int ALLOC_W = 3,
  localparam int OCC_W  = $clog2(ROB_SZ + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ALLOC_W-1:0] alloc_cnt,
  input  logic [POP_W-1:0]   pop_cnt,
  output logic [OCC_W-1:0]   rob_free,
  output logic               rob_empty,
  output logic               occ_upd
);

  logic [OCC_W-1:0] occ_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q   <= '0;
      occ_upd <= 1'b0;
    end else begin
      occ_q   <= occ_q + OCC_W'(alloc_cnt) - OCC_W'(pop_cnt);
      occ_upd <= (alloc_cnt != '0) || (pop_cnt != '0);
    end
  end

  assign rob_free  = OCC_W'(ROB_SZ) - occ_q;
  assign rob_empty = (occ_q == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    OCC_W'(pop_cnt) <= occ_q);  // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(occ_q) + 32'(alloc_cnt) - 32'(pop_cnt)) <= ROB_SZ);  // R9

endmodule

// File: rtl/retire_trap.sv
`timescale 1ns/1ps
module retire_trap #(
  parameter int TRAP_LAT = 3,
  localparam int TW      = $clog2(TRAP_LAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_go,
  output logic busy,
  output logic squash
);

  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              tmr_q <= '0;
    else if (trap_go)        tmr_q <= TW'(TRAP_LAT);
    else if (tmr_q != '0)    tmr_q <= tmr_q - 1'b1;
  end

  assign busy   = (tmr_q != '0);
  assign squash = (tmr_q == TW'(1));

  AST_TRAP_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trap_go));  // R6
  AST_TRAP_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !trap_go);  // R6

endmodule

// File: rtl/retire_unit.sv
`timescale 1ns/1ps
module retire_unit #(
  parameter int COMMIT_W   = 2,
  parameter int WIN        = 4,
  parameter int SEQ_W      = 8,
  parameter int AR_W       = 5,
  parameter int PR_W       = 6,
  parameter int PC_W       = 16,
  parameter int INST_BYTES = 4,
  parameter int ROB_SZ     = 16,
  parameter int TRAP_LAT   = 3,
  parameter int ALLOC_W    = 3,
  parameter int BW_W       = 16,
  localparam int POP_W     = $clog2(WIN + 1),
  localparam int CC_W      = $clog2(COMMIT_W + 1),
  localparam int OCC_W     = $clog2(ROB_SZ + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     grant,
  input  logic                     stores_pend,
  input  logic [ALLOC_W-1:0]       alloc_cnt,
  input  logic [WIN-1:0]           hd_valid,
  input  logic [WIN-1:0]           hd_ready,
  input  logic [WIN-1:0]           hd_squashed,
  input  logic [WIN-1:0]           hd_executed,
  input  logic [WIN-1:0]           hd_nonspec,
  input  logic [WIN-1:0]           hd_barrier,
  input  logic [WIN-1:0]           hd_load,
  input  logic [WIN-1:0]           hd_fault,
  input  logic [WIN-1:0]           hd_dst_en,
  input  logic [WIN*SEQ_W-1:0]     hd_seq,
  input  logic [WIN*AR_W-1:0]      hd_arch,
  input  logic [WIN*PR_W-1:0]      hd_phys,
  input  logic [WIN*PC_W-1:0]      hd_npc,
  output logic [POP_W-1:0]         pop_cnt,
  output logic [CC_W-1:0]          commit_cnt,
  output logic [COMMIT_W-1:0]      map_we,
  output logic [COMMIT_W*AR_W-1:0] map_arch,
  output logic [COMMIT_W*PR_W-1:0] map_phys,
  output logic                     nonspec_vld,
  output logic                     uncached_vld,
  output logic [SEQ_W-1:0]         req_seq,
  output logic                     clr_ready,
  output logic                     trap_start,
  output logic                     trap_busy,
  output logic                     trap_squash,
  output logic                     done_vld,
  output logic [SEQ_W-1:0]         done_seq,
  output logic [PC_W-1:0]          arch_pc,
  output logic [PC_W-1:0]          arch_npc,
  output logic [OCC_W-1:0]         rob_free,
  output logic                     rob_empty,
  output logic                     occ_upd,
  output logic [BW_W-1:0]          bw_events
);

  logic            scan_en;
  logic [PC_W-1:0] last_npc;

  assign scan_en = grant && !trap_busy;

  retire_scan #(
    .COMMIT_W(COMMIT_W), .WIN(WIN), .SEQ_W(SEQ_W),
    .AR_W(AR_W), .PR_W(PR_W), .PC_W(PC_W)
  ) u_scan (
    .en(scan_en), .stores_pend(stores_pend),
    .hd_valid(hd_valid), .hd_ready(hd_ready), .hd_squashed(hd_squashed),
    .hd_executed(hd_executed), .hd_nonspec(hd_nonspec),
    .hd_barrier(hd_barrier), .hd_load(hd_load), .hd_fault(hd_fault),
    .hd_dst_en(hd_dst_en), .hd_seq(hd_seq), .hd_arch(hd_arch),
    .hd_phys(hd_phys), .hd_npc(hd_npc),
    .pop_cnt(pop_cnt), .commit_cnt(commit_cnt), .map_we(map_we),
    .map_arch(map_arch), .map_phys(map_phys),
    .nonspec_vld(nonspec_vld), .uncached_vld(uncached_vld),
    .req_seq(req_seq), .clr_ready(clr_ready), .trap_go(trap_start),
    .done_vld(done_vld), .done_seq(done_seq), .last_npc(last_npc)
  );

  retire_trap #(.TRAP_LAT(TRAP_LAT)) u_trap (
    .clk(clk), .rst_n(rst_n), .trap_go(trap_start),
    .busy(trap_busy), .squash(trap_squash)
  );

  retire_occ #(.ROB_SZ(ROB_SZ), .POP_W(POP_W), .ALLOC_W(ALLOC_W)) u_occ (
    .clk(clk), .rst_n(rst_n), .alloc_cnt(alloc_cnt), .pop_cnt(pop_cnt),
    .rob_free(rob_free), .rob_empty(rob_empty), .occ_upd(occ_upd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arch_pc   <= '0;
      arch_npc  <= '0;
      bw_events <= '0;
    end else begin
      if (done_vld) begin
        arch_pc  <= last_npc;
        arch_npc <= last_npc + PC_W'(INST_BYTES);
      end
      if (commit_cnt == CC_W'(COMMIT_W)) bw_events <= bw_events + 1'b1;
    end
  end

  AST_WIDTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    commit_cnt <= CC_W'(COMMIT_W));  // R1
  AST_ONE_SIDE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nonspec_vld, uncached_vld, trap_start}));  // R4
  AST_NS_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    nonspec_vld |-> (commit_cnt == '0 && !stores_pend));  // R4
  AST_HALT_IN_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_busy |-> (pop_cnt == '0));  // R6
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_cnt == '0) |=> $stable(arch_pc));  // R8
  AST_BW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_cnt == CC_W'(COMMIT_W)) |=> (bw_events == $past(bw_events) + 1'b1));  // R10

endmodule

// File: tb/retire_unit_tb.sv
`timescale 1ns/1ps
module retire_unit_tb;
  localparam int W = 2, WIN = 4, SEQ_W = 8, AR_W = 5, PR_W = 6, PC_W = 16;
  localparam int IB = 4, ROB_SZ = 16, LAT = 3, ALLOC_W = 3, BW_W = 16;
  localparam int POP_W = $clog2(WIN + 1), CC_W = $clog2(W + 1);
  localparam int OCC_W = $clog2(ROB_SZ + 1);

  logic clk = 0, rst_n = 0, grant = 0, stores_pend = 0;
  logic [ALLOC_W-1:0] alloc_cnt = '0;
  logic [WIN-1:0] hv = '0, hr = '0, hs = '0, he = '0, hn = '0, hb = '0, hl = '0, hf = '0, hd = '0;
  logic [WIN*SEQ_W-1:0] hseq = '0;
  logic [WIN*AR_W-1:0] harch = '0;
  logic [WIN*PR_W-1:0] hphys = '0;
  logic [WIN*PC_W-1:0] hnpc = '0;
  logic [POP_W-1:0] pop_cnt;
  logic [CC_W-1:0] commit_cnt;
  logic [W-1:0] map_we;
  logic [W*AR_W-1:0] map_arch;
  logic [W*PR_W-1:0] map_phys;
  logic nonspec_vld, uncached_vld, clr_ready, trap_start, trap_busy, trap_squash, done_vld;
  logic [SEQ_W-1:0] req_seq, done_seq;
  logic [PC_W-1:0] arch_pc, arch_npc;
  logic [OCC_W-1:0] rob_free;
  logic rob_empty, occ_upd;
  logic [BW_W-1:0] bw_events;

  always #10 clk = ~clk;  // 50 MHz

  retire_unit u_dut (
    .clk(clk), .rst_n(rst_n), .grant(grant), .stores_pend(stores_pend),
    .alloc_cnt(alloc_cnt), .hd_valid(hv), .hd_ready(hr), .hd_squashed(hs),
    .hd_executed(he), .hd_nonspec(hn), .hd_barrier(hb), .hd_load(hl),
    .hd_fault(hf), .hd_dst_en(hd), .hd_seq(hseq), .hd_arch(harch),
    .hd_phys(hphys), .hd_npc(hnpc), .pop_cnt(pop_cnt), .commit_cnt(commit_cnt),
    .map_we(map_we), .map_arch(map_arch), .map_phys(map_phys),
    .nonspec_vld(nonspec_vld), .uncached_vld(uncached_vld), .req_seq(req_seq),
    .clr_ready(clr_ready), .trap_start(trap_start), .trap_busy(trap_busy),
    .trap_squash(trap_squash), .done_vld(done_vld), .done_seq(done_seq),
    .arch_pc(arch_pc), .arch_npc(arch_npc), .rob_free(rob_free),
    .rob_empty(rob_empty), .occ_upd(occ_upd), .bw_events(bw_events)
  );

  int n_chk = 0, n_bad = 0;
  // model state
  int m_pc = 0, m_npc = 0, m_occ = 0, m_tmr = 0, m_bw = 0, m_upd = 0;
  // model per-cycle results
  int e_pop, e_com, e_ns, e_unc, e_req, e_clr, e_trap, e_dv, e_ds, e_last;
  int e_we [W];
  int e_ar [W];
  int e_ph [W];

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic model_cycle();
    bit stop;
    e_pop = 0; e_com = 0; e_ns = 0; e_unc = 0; e_req = 0; e_clr = 0;
    e_trap = 0; e_dv = 0; e_ds = 0; e_last = 0;
    for (int k = 0; k < W; k++) begin e_we[k] = 0; e_ar[k] = 0; e_ph[k] = 0; end
    stop = !(grant && m_tmr == 0);
    for (int i = 0; i < WIN && !stop; i++) begin
      if (!hv[i] || !hr[i] || e_com >= W) stop = 1;
      else if (hs[i]) e_pop++;
      else if (!he[i]) begin
        if (hn[i] || hb[i]) begin
          if (!stores_pend && e_com == 0) begin e_ns = 1; e_clr = 1; e_req = int'(hseq[i*SEQ_W +: SEQ_W]); end
        end else if (hl[i]) begin
          e_unc = 1; e_clr = 1; e_req = int'(hseq[i*SEQ_W +: SEQ_W]);
        end
        stop = 1;
      end else if (hf[i]) begin
        if (!stores_pend && e_com == 0) e_trap = 1;
        stop = 1;
      end else begin
        if (hd[i]) begin
          e_we[e_com] = 1;
          e_ar[e_com] = int'(harch[i*AR_W +: AR_W]);
          e_ph[e_com] = int'(hphys[i*PR_W +: PR_W]);
        end
        e_dv = 1; e_ds = int'(hseq[i*SEQ_W +: SEQ_W]); e_last = int'(hnpc[i*PC_W +: PC_W]);
        e_com++; e_pop++;
      end
    end
  endtask

  task automatic drive_random();
    int nv, amax;
    nv = $urandom_range(WIN);
    if (nv > m_occ) nv = m_occ;
    for (int i = 0; i < WIN; i++) begin
      hv[i] = (i < nv);
      hr[i] = ($urandom_range(99) < 88);
      hs[i] = ($urandom_range(99) < 20);
      he[i] = ($urandom_range(99) < 80);
      hn[i] = ($urandom_range(99) < 12);
      hb[i] = ($urandom_range(99) < 6);
      hl[i] = ($urandom_range(99) < 30);
      hf[i] = ($urandom_range(99) < 7);
      hd[i] = ($urandom_range(99) < 75);
      hseq[i*SEQ_W +: SEQ_W] = SEQ_W'($urandom);
      harch[i*AR_W +: AR_W] = AR_W'($urandom);
      hphys[i*PR_W +: PR_W] = PR_W'($urandom);
      hnpc[i*PC_W +: PC_W] = PC_W'($urandom);
    end
    grant = ($urandom_range(99) < 90);
    stores_pend = ($urandom_range(99) < 30);
    amax = ROB_SZ - m_occ;
    if (amax > 3) amax = 3;
    alloc_cnt = ALLOC_W'($urandom_range(amax));
  endtask

  // one clock: inputs already driven at negedge; compare, then advance model
  task automatic step();
    #2;
    model_cycle();
    chk("R1", "commit_cnt", int'(commit_cnt), e_com);
    chk("R2", "pop_cnt", int'(pop_cnt), e_pop);
    chk("R3", "pop_cnt_vs_commit", int'(pop_cnt) - int'(commit_cnt), e_pop - e_com);
    chk("R4", "nonspec_vld", int'(nonspec_vld), e_ns);
    chk("R5", "uncached_vld", int'(uncached_vld), e_unc);
    chk("R5", "req_seq", int'(req_seq), e_req);
    chk("R5", "clr_ready", int'(clr_ready), e_clr);
    chk("R6", "trap_start", int'(trap_start), e_trap);
    chk("R6", "trap_busy", int'(trap_busy), int'(m_tmr != 0));
    chk("R6", "trap_squash", int'(trap_squash), int'(m_tmr == 1));
    for (int k = 0; k < W; k++) begin
      chk("R7", "map_we", int'(map_we[k]), e_we[k]);
      chk("R7", "map_arch", int'(map_arch[k*AR_W +: AR_W]), e_ar[k]);
      chk("R7", "map_phys", int'(map_phys[k*PR_W +: PR_W]), e_ph[k]);
    end
    chk("R7", "done_vld", int'(done_vld), e_dv);
    chk("R7", "done_seq", int'(done_seq), e_ds);
    chk("R8", "arch_pc", int'(arch_pc), m_pc);
    chk("R8", "arch_npc", int'(arch_npc), m_npc);
    chk("R9", "rob_free", int'(rob_free), ROB_SZ - m_occ);
    chk("R9", "rob_empty", int'(rob_empty), int'(m_occ == 0));
    chk("R9", "occ_upd", int'(occ_upd), m_upd);
    chk("R10", "bw_events", int'(bw_events), m_bw);
    @(posedge clk);
    if (e_dv != 0) begin m_pc = e_last; m_npc = (e_last + IB) & 16'hffff; end
    if (e_com == W) m_bw++;
    m_upd = int'(alloc_cnt != 0 || e_pop != 0);
    m_occ = m_occ + int'(alloc_cnt) - e_pop;
    if (e_trap != 0) m_tmr = LAT;
    else if (m_tmr != 0) m_tmr--;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #2;
    // reset state checks
    chk("R9", "reset rob_free", int'(rob_free), ROB_SZ);
    chk("R9", "reset rob_empty", int'(rob_empty), 1);
    chk("R8", "reset arch_pc", int'(arch_pc), 0);
    chk("R10", "reset bw_events", int'(bw_events), 0);
    chk("R6", "reset trap_busy", int'(trap_busy), 0);
    // fill the buffer a little
    alloc_cnt = 3'd3;
    step(); step();
    alloc_cnt = '0;
    // directed: squashed entry between two retirements, then nonspec in slot 2
    hv = 4'b1111; hr = 4'b1111; hs = 4'b0010; he = 4'b0111; hn = 4'b1000;
    hb = '0; hl = '0; hf = '0; hd = 4'b1111; stores_pend = 0; grant = 1;
    for (int i = 0; i < WIN; i++) begin
      hseq[i*SEQ_W +: SEQ_W] = SEQ_W'(10 + i);
      harch[i*AR_W +: AR_W] = AR_W'(i + 1);
      hphys[i*PR_W +: PR_W] = PR_W'(i + 20);
      hnpc[i*PC_W +: PC_W] = PC_W'(16'h100 + 4 * i);
    end
    step();  // R1 R3 R7: pops 3, commits 2, nonspec blocked by width
    // directed: fault in first slot with stores pending, then drained
    hv = 4'b0001; hs = '0; he = 4'b0001; hn = '0; hf = 4'b0001; stores_pend = 1;
    step();  // R6 waits
    stores_pend = 0;
    step();  // R6 trap starts
    for (int c = 0; c < LAT + 1; c++) step();
    // random phase
    for (int c = 0; c < 4000; c++) begin
      drive_random();
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule